// File: doc/BRIEF.md
# Exception entry and return controller

This block tracks the privilege state of a processor with four privilege levels, numbered 0 to 3, where a larger number means more privilege. It holds the current level, the current execution width (32-bit or 64-bit), which stack pointer is selected and the current security state. These values change only when an exception is taken or when an exception return is requested.

When an exception is taken, the block records the return PC and a state word describing the interrupted context. Both go into storage that belongs to the level being entered. The block then moves to that level, chooses its width and selects the level's own stack pointer.

On a return request, the block reads the state word saved for the level being left. From that word it decides whether the return is legal. A legal return restores level, width, stack selection, flags and PC together in one cycle. An illegal return changes nothing and raises a one-cycle pulse. A handler may rewrite a saved state word through a write port before it returns.

Top module: `exc_level_ctrl`

## Requirements
- R1: While reset is held, the block sits at level 3 with the dedicated stack selected and the secure indication set. Its width is 64-bit if `rst_w64` is 1 and 32-bit otherwise. `pc_valid`, `illegal_ret` and `flags_out` are 0.
- R2: An exception taken with `entry_req` goes to the effective target, the largest of `entry_level`, the current level and 1. In that cycle the effective target's return-address slot stores `entry_pc`. Its state word stores, from bit 0 upward: the current level (2 bits), bit 2 = 1 if the current width is 32-bit, bit 3 = the current stack selection, and bits 7..4 = `cur_flags`. The outputs show the new level one cycle after the request.
- R3: After an exception, the width is 64-bit if the current width is 64-bit or if `lvl_w64_cfg[target]` is 1. A 64-bit context therefore never becomes 32-bit on exception entry.
- R4: Every exception entry selects the dedicated stack of the target level (`sp_dedicated` = 1).
- R5: A legal return takes effect one cycle after `ret_req`, and all of the following change in that same cycle. The level is set from bits 1..0 of the current level's state word. The width is set to the inverse of bit 2. `sp_dedicated` is set from bit 3 and `flags_out` from bits 7..4. `pc_out` is set to the current level's saved return address, and `pc_valid` pulses for one cycle.
- R6: A return is illegal when it is requested at level 0, or when the saved level is higher than the current level.
- R7: A return is also illegal in either of two cases. The first is that the saved 32-bit bit equals `lvl_w64_cfg[saved level]`, meaning the saved width disagrees with the configured width. The second is that the current width is 32-bit and the saved width is 64-bit.
- R8: An illegal return leaves level, width, stack selection, flags and security unchanged. It gives a one-cycle `illegal_ret` pulse with no `pc_valid`.
- R9: Level 3 is always reported secure. Below level 3, `secure` is the inverse of a latched copy of `ns_lower_cfg`. That copy is taken only by a legal return to a lower level, so a change of `ns_lower_cfg` has no effect until such a return.
- R10: When `entry_req` and `ret_req` are high together, the exception is taken and the return is ignored.
- R11: A write with `sw_wr_en` (and no `entry_req`) replaces the state word of level `sw_wr_level`, and the next return from that level uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_w64 | input | 1 | Width at reset, 1 = 64-bit |
| lvl_w64_cfg | input | NUM_LVL | Configured width per level, 1 = 64-bit |
| ns_lower_cfg | input | 1 | Level-3 control: lower levels run non-secure when 1 |
| entry_req | input | 1 | Take an exception |
| entry_level | input | LVL_W | Requested target level |
| entry_pc | input | PC_W | Return address to save |
| cur_flags | input | FLAG_W | Current condition flags to save |
| ret_req | input | 1 | Exception return request |
| sw_wr_en | input | 1 | Write a saved state word |
| sw_wr_level | input | LVL_W | Level whose state word is written |
| sw_wr_data | input | FLAG_W+4 | State word to write |
| cur_level | output | LVL_W | Current level |
| cur_w64 | output | 1 | Current width, 1 = 64-bit |
| sp_dedicated | output | 1 | 1 = level's own stack, 0 = shared level-0 stack |
| secure | output | 1 | Current security state, 1 = secure |
| flags_out | output | FLAG_W | Flags restored by the last legal return |
| pc_valid | output | 1 | One-cycle pulse: `pc_out` holds a restored PC |
| pc_out | output | PC_W | Restored PC |
| illegal_ret | output | 1 | One-cycle pulse on an illegal return |

## Verification
Some properties are checked on every cycle. The level moves only after a request, and an entry neither narrows the width nor leaves the shared stack selected. A return never widens a 32-bit context, an illegal return freezes the state, and level 3 is always secure. Other behaviour can only be shown by the bench's scenarios against its model of the saved words. These are the exact saved word and PC written on entry, and the clamping of a low entry target. They also include each individual illegal-return cause, the deferred security change and the entry-over-return priority.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 4;
  // saved state word layout
  localparam int F_LVL   = 0;
  localparam int F_W32   = 2;
  localparam int F_SP    = 3;
  localparam int F_FLAGS = 4;
endpackage

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int NUM_LVL = 4,
  parameter int PC_W    = 32,
  parameter int SW_W    = 8,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             we_pc,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [SW_W-1:0]  wr_sw,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [LVL_W-1:0] rd_lvl,
  output logic [SW_W-1:0]  rd_sw,
  output logic [PC_W-1:0]  rd_pc
);
  logic [SW_W-1:0] sw_mem [NUM_LVL];
  logic [PC_W-1:0] pc_mem [NUM_LVL];

  always_ff @(posedge clk) begin
    if (we) sw_mem[wr_lvl] <= wr_sw;
    if (we && we_pc) pc_mem[wr_lvl] <= wr_pc;
  end

  assign rd_sw = sw_mem[rd_lvl];
  assign rd_pc = pc_mem[rd_lvl];
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [LVL_W-1:0]   req_lvl,
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               cur_w64,
  input  logic [NUM_LVL-1:0] w64_cfg,
  output logic [LVL_W-1:0]   tgt_lvl,
  output logic               tgt_w64
);
  always_comb begin
    tgt_lvl = req_lvl;
    if (cur_lvl > tgt_lvl) tgt_lvl = cur_lvl;
    if (tgt_lvl == '0) tgt_lvl = LVL_W'(1);
    tgt_w64 = cur_w64 | w64_cfg[tgt_lvl];
  end
endmodule

// File: rtl/exc_ret_check.sv
module exc_ret_check
  import exc_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int FLAG_W  = 4,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int SW_W   = FLAG_W + 4
) (
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               cur_w64,
  input  logic [SW_W-1:0]    saved_sw,
  input  logic [NUM_LVL-1:0] w64_cfg,
  output logic               bad,
  output logic [LVL_W-1:0]   tgt_lvl,
  output logic               tgt_w64,
  output logic               tgt_sp,
  output logic [FLAG_W-1:0]  tgt_flags
);
  logic s32;
  always_comb begin
    tgt_lvl   = saved_sw[F_LVL +: LVL_W];
    s32       = saved_sw[F_W32];
    tgt_w64   = ~s32;
    tgt_sp    = saved_sw[F_SP];
    tgt_flags = saved_sw[F_FLAGS +: FLAG_W];
    bad = (cur_lvl == '0) || (tgt_lvl > cur_lvl)
       || (s32 == w64_cfg[tgt_lvl]) || (!cur_w64 && !s32);
  end
endmodule

// File: rtl/exc_level_ctrl.sv
module exc_level_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int PC_W    = 32,
  parameter int FLAG_W  = 4,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int SW_W   = FLAG_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_w64,
  input  logic [NUM_LVL-1:0] lvl_w64_cfg,
  input  logic               ns_lower_cfg,
  input  logic               entry_req,
  input  logic [LVL_W-1:0]   entry_level,
  input  logic [PC_W-1:0]    entry_pc,
  input  logic [FLAG_W-1:0]  cur_flags,
  input  logic               ret_req,
  input  logic               sw_wr_en,
  input  logic [LVL_W-1:0]   sw_wr_level,
  input  logic [SW_W-1:0]    sw_wr_data,
  output logic [LVL_W-1:0]   cur_level,
  output logic               cur_w64,
  output logic               sp_dedicated,
  output logic               secure,
  output logic [FLAG_W-1:0]  flags_out,
  output logic               pc_valid,
  output logic [PC_W-1:0]    pc_out,
  output logic               illegal_ret
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

  logic [LVL_W-1:0]  ent_lvl, ret_lvl, wr_lvl;
  logic              ent_w64, ret_w64, ret_sp, ret_bad, ns_lat, bank_we;
  logic [FLAG_W-1:0] ret_flags;
  logic [SW_W-1:0]   rd_sw, wr_sw;
  logic [PC_W-1:0]   rd_pc;

  exc_entry_calc #(.NUM_LVL(NUM_LVL)) i_entry (
    .req_lvl(entry_level), .cur_lvl(cur_level), .cur_w64(cur_w64),
    .w64_cfg(lvl_w64_cfg), .tgt_lvl(ent_lvl), .tgt_w64(ent_w64)
  );

  always_comb begin
    bank_we = entry_req | sw_wr_en;
    wr_lvl  = entry_req ? ent_lvl : sw_wr_level;
    wr_sw   = sw_wr_data;
    if (entry_req) begin
      wr_sw = '0;
      wr_sw[F_LVL +: LVL_W]    = cur_level;
      wr_sw[F_W32]             = ~cur_w64;
      wr_sw[F_SP]              = sp_dedicated;
      wr_sw[F_FLAGS +: FLAG_W] = cur_flags;
    end
  end

  exc_save_bank #(.NUM_LVL(NUM_LVL), .PC_W(PC_W), .SW_W(SW_W)) i_bank (
    .clk(clk), .we(bank_we), .we_pc(entry_req), .wr_lvl(wr_lvl),
    .wr_sw(wr_sw), .wr_pc(entry_pc), .rd_lvl(cur_level),
    .rd_sw(rd_sw), .rd_pc(rd_pc)
  );

  exc_ret_check #(.NUM_LVL(NUM_LVL), .FLAG_W(FLAG_W)) i_ret (
    .cur_lvl(cur_level), .cur_w64(cur_w64), .saved_sw(rd_sw),
    .w64_cfg(lvl_w64_cfg), .bad(ret_bad), .tgt_lvl(ret_lvl),
    .tgt_w64(ret_w64), .tgt_sp(ret_sp), .tgt_flags(ret_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_level    <= TOP_LVL;
      cur_w64      <= rst_w64;
      sp_dedicated <= 1'b1;
      secure       <= 1'b1;
      ns_lat       <= 1'b0;
      flags_out    <= '0;
      pc_valid     <= 1'b0;
      pc_out       <= '0;
      illegal_ret  <= 1'b0;
    end else begin
      pc_valid    <= 1'b0;
      illegal_ret <= 1'b0;
      if (entry_req) begin
        cur_level    <= ent_lvl;
        cur_w64      <= ent_w64;
        sp_dedicated <= 1'b1;
        secure       <= (ent_lvl == TOP_LVL) | ~ns_lat;
      end else if (ret_req) begin
        if (ret_bad) begin
          illegal_ret <= 1'b1;
        end else begin
          cur_level    <= ret_lvl;
          cur_w64      <= ret_w64;
          sp_dedicated <= ret_sp;
          flags_out    <= ret_flags;
          pc_out       <= rd_pc;
          pc_valid     <= 1'b1;
          if (ret_lvl < cur_level) begin
            ns_lat <= ns_lower_cfg;
            secure <= (ret_lvl == TOP_LVL) | ~ns_lower_cfg;
          end else begin
            secure <= (ret_lvl == TOP_LVL) | ~ns_lat;
          end
        end
      end
    end
  end
endmodule

// File: rtl/exc_level_ctrl_chk.sv
module exc_level_ctrl_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             entry_req,
  input logic             ret_req,
  input logic [LVL_W-1:0] cur_level,
  input logic             cur_w64,
  input logic             sp_dedicated,
  input logic             secure,
  input logic             pc_valid,
  input logic             illegal_ret
);
  AST_LEVEL_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (cur_level != $past(cur_level)) |-> $past(entry_req || ret_req)); // R2
  AST_ENTRY_KEEPS_64: assert property (@(posedge clk) disable iff (rst)
    (entry_req && cur_w64) |=> cur_w64); // R3
  AST_ENTRY_OWN_STACK: assert property (@(posedge clk) disable iff (rst)
    entry_req |=> sp_dedicated); // R4
  AST_RET_KEEPS_32: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !entry_req && !cur_w64) |=> !cur_w64); // R7
  AST_PC_ONLY_ON_RET: assert property (@(posedge clk) disable iff (rst)
    pc_valid |-> (!illegal_ret && $past(ret_req) && !$past(entry_req))); // R5
  AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    illegal_ret |-> ($stable(cur_level) && $stable(cur_w64)
                     && $stable(sp_dedicated) && $stable(secure))); // R8
  AST_TOP_SECURE: assert property (@(posedge clk) disable iff (rst)
    (cur_level == LVL_W'(3)) |-> secure); // R9
endmodule

bind exc_level_ctrl exc_level_ctrl_chk #(.LVL_W(LVL_W)) i_chk (.*);

// File: tb/test_exc_level_ctrl.sv
module test_exc_level_ctrl;
  logic clk = 0, rst = 1, rst_w64 = 1;
  logic [3:0] lvl_w64_cfg = 4'b1110;
  logic ns_lower_cfg = 0, entry_req = 0, ret_req = 0, sw_wr_en = 0;
  logic [1:0] entry_level = 0, sw_wr_level = 0;
  logic [31:0] entry_pc = 0;
  logic [3:0] cur_flags = 0;
  logic [7:0] sw_wr_data = 0;
  logic [1:0] cur_level;
  logic cur_w64, sp_dedicated, secure, pc_valid, illegal_ret;
  logic [3:0] flags_out;
  logic [31:0] pc_out;

  exc_level_ctrl i_exc_level_ctrl (.*);

  always #10 clk = ~clk;

  typedef struct {
    int tag; string req;
    logic [1:0] lvl; logic w64, sp, sec, ill, pcv;
    logic [31:0] pc; logic [3:0] fl;
  } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [1:0] m_lvl; logic m_w64, m_sp, m_sec, m_ns;
  logic [3:0] m_fl; logic [31:0] m_pc;
  logic [31:0] m_elr [4]; logic [7:0] m_sw [4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    logic ok;
    checks++;
    ok = (cur_level === e.lvl) && (cur_w64 === e.w64) && (sp_dedicated === e.sp)
      && (secure === e.sec) && (illegal_ret === e.ill) && (pc_valid === e.pcv)
      && (flags_out === e.fl) && (!e.pcv || pc_out === e.pc);
    if (!ok) begin
      errors++;
      $display("FAIL %s: got lvl=%0d w64=%b sp=%b sec=%b ill=%b pcv=%b pc=%h fl=%h exp lvl=%0d w64=%b sp=%b sec=%b ill=%b pcv=%b pc=%h fl=%h",
        e.req, cur_level, cur_w64, sp_dedicated, secure, illegal_ret, pc_valid, pc_out, flags_out,
        e.lvl, e.w64, e.sp, e.sec, e.ill, e.pcv, e.pc, e.fl);
    end
  endtask

  always @(negedge clk)
    if (q.size() > 0 && q[0].tag == cyc) compare(q.pop_front());

  function automatic exp_t snap(input string req, input logic ill, input logic pcv);
    exp_t e;
    e.tag = cyc + 1; e.req = req; e.lvl = m_lvl; e.w64 = m_w64; e.sp = m_sp;
    e.sec = m_sec; e.ill = ill; e.pcv = pcv; e.pc = m_pc; e.fl = m_fl;
    return e;
  endfunction

  task automatic do_reset(input logic w);
    exp_t e;
    rst = 1; rst_w64 = w;
    @(negedge clk); @(negedge clk);
    m_lvl = 3; m_w64 = w; m_sp = 1; m_sec = 1; m_ns = 0; m_fl = 0; m_pc = 0;
    e = snap("R1", 0, 0);
    compare(e);
    rst = 0;
  endtask

  task automatic step(input string req, input logic en, input logic [1:0] el,
                      input logic [31:0] pc, input logic [3:0] fl, input logic rr,
                      input logic swe, input logic [1:0] swl, input logic [7:0] swd);
    logic ill, pcv, bad, s32;
    logic [1:0] t, tg, lv;
    logic [7:0] s;
    entry_req = en; entry_level = el; entry_pc = pc; cur_flags = fl;
    ret_req = rr; sw_wr_en = swe; sw_wr_level = swl; sw_wr_data = swd;
    ill = 0; pcv = 0;
    if (en) begin
      t = el; if (m_lvl > t) t = m_lvl; if (t == 0) t = 1;
      m_sw[t] = {fl, m_sp, ~m_w64, m_lvl}; m_elr[t] = pc;
      m_w64 = m_w64 | lvl_w64_cfg[t]; m_lvl = t; m_sp = 1;
      m_sec = (t == 3) ? 1'b1 : ~m_ns;
    end else if (rr) begin
      lv = m_lvl; s = m_sw[lv]; tg = s[1:0]; s32 = s[2];
      bad = (lv == 0) || (tg > lv) || (s32 == lvl_w64_cfg[tg]) || (!m_w64 && !s32);
      if (bad) ill = 1;
      else begin
        if (tg < lv) m_ns = ns_lower_cfg;
        m_lvl = tg; m_w64 = ~s32; m_sp = s[3]; m_fl = s[7:4]; m_pc = m_elr[lv];
        pcv = 1; m_sec = (tg == 3) ? 1'b1 : ~m_ns;
      end
    end
    if (swe && !en) m_sw[swl] = swd;
    q.push_back(snap(req, ill, pcv));
    @(negedge clk);
    entry_req = 0; ret_req = 0; sw_wr_en = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b1);                                          // R1
    ns_lower_cfg = 1;
    step("R2", 1, 2'd3, 32'h100, 4'hA, 0, 0, 0, 0);          // entry 3->3
    step("R11", 0, 0, 0, 0, 0, 1, 2'd3, {4'h5, 1'b0, 1'b1, 2'd0});
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0);                      // legal to level 0, 32-bit
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);                      // non-secure latched at level 0
    step("R6", 0, 0, 0, 0, 1, 0, 0, 0);                      // return at level 0 illegal
    step("R3", 1, 2'd1, 32'h200, 4'h3, 0, 0, 0, 0);          // 32 -> 64 on entry
    step("R2", 1, 2'd0, 32'h204, 4'h6, 0, 0, 0, 0);          // low target clamped to current
    lvl_w64_cfg = 4'b0110;
    step("R3", 1, 2'd3, 32'h300, 4'h7, 0, 0, 0, 0);          // 64 kept though level 3 cfg 32
    lvl_w64_cfg = 4'b1110;
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0);                      // legal 3->1, sp dedicated restored
    lvl_w64_cfg = 4'b1100;
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0);                      // saved 64 vs cfg 32 at level 1
    lvl_w64_cfg = 4'b1110;
    step("R11", 0, 0, 0, 0, 0, 1, 2'd1, {4'h9, 1'b0, 1'b0, 2'd2});
    step("R6", 0, 0, 0, 0, 1, 0, 0, 0);                      // saved level above current
    ns_lower_cfg = 0;
    step("R9", 1, 2'd2, 32'h400, 4'h1, 0, 0, 0, 0);          // cfg change not yet applied
    step("R9", 0, 0, 0, 0, 1, 0, 0, 0);                      // drop 2->1 applies secure
    step("R10", 1, 2'd3, 32'h500, 4'h2, 1, 0, 0, 0);         // entry wins over return
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0);                      // return 3->2
    // 32-bit context: return to 64-bit saved width is illegal
    do_reset(1'b0);                                          // R1
    lvl_w64_cfg = 4'b0001;
    step("R3", 1, 2'd3, 32'h600, 4'h4, 0, 0, 0, 0);          // stays 32
    step("R11", 0, 0, 0, 0, 0, 1, 2'd3, {4'hC, 1'b0, 1'b0, 2'd0});
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0);                      // 32 -> 64 on return
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);                      // still frozen, no pulse
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule